// File: doc/BRIEF.md
# Multi-Algorithm Output Port Predictor

This block sits on one input channel of a five-port mesh router and guesses which output port the next head flit on that channel will ask for, so that routing and arbitration can be started before the flit arrives. Three guessing algorithms run side by side on every head flit. The first is a fixed straight-through guess. The second repeats the last port used. The third picks the port with the highest usage count. One of the three drives the prediction at any time.

The active algorithm is chosen in one of two ways. In static mode a configuration input fixes the choice. In dynamic mode a scoreboard counts, for each algorithm, the head flits it would have guessed correctly. At the end of every selection interval (software normally programs 10,000 cycles) it makes the best scorer active and clears the scores. One cycle after each head flit, the block reports whether the prediction held at that moment was right.

Ports are one-hot over five bits: bit 0 local, bit 1 X+, bit 2 X-, bit 3 Y+, bit 4 Y-. The parameter `IN_PORT` names the input side the block serves.

Top module: `outport_predictor`

## Requirements
- R1: `pred_valid` is high exactly while `chan_idle` is high. `pred_port` carries the active guess regardless of `chan_idle`.
- R2: The straight algorithm (select code 0) predicts the opposite side of `IN_PORT`: X+ and X- swap, Y+ and Y- swap, and local maps to X+.
- R3: The last-used algorithm (select code 1) predicts the port of the most recent head flit. After reset it predicts the straight port.
- R4: The frequency algorithm (select code 2) predicts the port with the largest usage count. Ties go to the lowest bit index, so after reset it predicts local (00001).
- R5: Each head flit adds one to its port's usage count. When that count would reach the all-ones value, every count is halved instead, and the incremented port takes the value all-ones shifted right by one. No count ever holds all-ones.
- R6: With `dyn_mode` low, `static_sel` picks the active algorithm at once. Code 3 selects the straight algorithm.
- R7: With `dyn_mode` high, each algorithm's score rises by one (saturating) on every head flit it predicts correctly. On the `interval`-th cycle after entering dynamic mode or after the previous boundary, the highest scorer becomes active, and the active choice changes at no other time. An `interval` of 0 acts as 1.
- R8: All scores are zero the cycle after a boundary and throughout static mode. A tie at a boundary goes to the lowest select code.
- R9: One cycle after `head_valid`, `hit_valid` is high and `hit` tells whether `head_port` equalled `pred_port` in the cycle it was presented. At all other times `hit_valid` is low.
- R10: `pred_port` is always exactly one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_idle | input | 1 | Input channel holds no packet |
| head_valid | input | 1 | A head flit's routed port is presented this cycle |
| head_port | input | 5 | One-hot routed output port of that head flit |
| dyn_mode | input | 1 | 1 = adaptive selection, 0 = static |
| static_sel | input | 2 | Algorithm code used in static mode |
| interval | input | INTERVAL_W | Selection interval length in cycles |
| pred_port | output | 5 | One-hot predicted output port |
| pred_valid | output | 1 | Prediction is offered |
| hit_valid | output | 1 | `hit` is meaningful this cycle |
| hit | output | 1 | Previous head flit matched its prediction |

## Verification
Assertions check on every cycle that the prediction stays one-hot, that no usage count reaches all-ones, and that halving leaves the other counts at half their earlier value. They also check that the last-used register follows each head flit, that scores are zero after a boundary, that the active choice moves only at a boundary in dynamic mode, and that the hit flag follows a head flit by one cycle. Which algorithm actually wins a dynamic interval, the tie rules, the straight mapping, and the exact predicted ports after a halving can only be shown by the bench's scenarios, which drive known flit sequences.

// File: rtl/op_pred_pkg.sv
package op_pred_pkg;
   localparam int NPORTS = 5;
   localparam int NALG   = 3;
   localparam int ALG_W  = 2;

   // One-hot port that continues in the same direction as the arriving flit.
   function automatic logic [NPORTS-1:0] straight_of(input int in_port);
      logic [NPORTS-1:0] r;
      case (in_port)
         1:       r = 5'b00100;
         2:       r = 5'b00010;
         3:       r = 5'b10000;
         4:       r = 5'b01000;
         default: r = 5'b00010;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/op_last_pred.sv
module op_last_pred #(
   parameter int NP = 5,
   parameter logic [NP-1:0] RESET_PORT = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd,
   input  logic [NP-1:0] port,
   output logic [NP-1:0] pred
);
   logic [NP-1:0] last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   last_q <= RESET_PORT;
      else if (upd) last_q <= port;
   end

   assign pred = last_q;

   assert_last_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> last_q == $past(port));
endmodule

// File: rtl/op_freq_pred.sv
module op_freq_pred #(
   parameter int NP    = 5,
   parameter int CNT_W = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd,
   input  logic [NP-1:0] port,
   output logic [NP-1:0] pred
);
   localparam logic [CNT_W-1:0] CMAX = '1;
   localparam logic [CNT_W-1:0] CHALF = CMAX >> 1;
   localparam logic [CNT_W-1:0] CEDGE = CMAX - 1'b1;

   if (CNT_W < 2) begin : g_bad_w
      $error("op_freq_pred: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q [NP];
   logic [NP-1:0]    at_edge;
   logic             halve;

   for (genvar i = 0; i < NP; i++) begin : g_cnt
      assign at_edge[i] = (cnt_q[i] == CEDGE);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cnt_q[i] <= '0;
         else if (upd) begin
            if (halve)        cnt_q[i] <= port[i] ? CHALF : (cnt_q[i] >> 1);
            else if (port[i]) cnt_q[i] <= cnt_q[i] + 1'b1;
         end
      end

      assert_freq_below_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q[i] != CMAX);
      assert_freq_halved_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (upd && halve && !port[i]) |=> cnt_q[i] == ($past(cnt_q[i]) >> 1));
   end

   assign halve = upd && |(port & at_edge);

   // Largest count wins, lowest index on ties.
   always_comb begin
      int best;
      best = 0;
      for (int i = 1; i < NP; i++)
         if (cnt_q[i] > cnt_q[best]) best = i;
      pred = '0;
      pred[best] = 1'b1;
   end
endmodule

// File: rtl/op_scoreboard.sv
module op_scoreboard #(
   parameter int NA         = 3,
   parameter int SEL_W      = 2,
   parameter int HIT_W      = 8,
   parameter int INTERVAL_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  dyn_mode,
   input  logic [INTERVAL_W-1:0] interval,
   input  logic [SEL_W-1:0]      static_sel,
   input  logic                  upd,
   input  logic [NA-1:0]         alg_hit,
   output logic [SEL_W-1:0]      active
);
   localparam logic [SEL_W-1:0] NA_V = SEL_W'(NA);
   localparam logic [HIT_W-1:0] HMAX = '1;

   if (NA < 1 || NA > (1 << SEL_W)) begin : g_bad_na
      $error("op_scoreboard: NA does not fit SEL_W");
   end

   logic [HIT_W-1:0]      score_q [NA];
   logic [INTERVAL_W-1:0] tick_q;
   logic                  boundary;
   logic [SEL_W-1:0]      active_q;
   logic [SEL_W-1:0]      static_map;
   logic [SEL_W-1:0]      winner;

   assign boundary   = dyn_mode && ({1'b0, tick_q} + 1'b1 >= {1'b0, interval});
   assign static_map = (static_sel < NA_V) ? static_sel : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    tick_q <= '0;
      else if (!dyn_mode || boundary) tick_q <= '0;
      else                           tick_q <= tick_q + 1'b1;
   end

   for (genvar a = 0; a < NA; a++) begin : g_score
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   score_q[a] <= '0;
         else if (!dyn_mode || boundary)               score_q[a] <= '0;
         else if (upd && alg_hit[a] && score_q[a] != HMAX) score_q[a] <= score_q[a] + 1'b1;
      end

      assert_score_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
         boundary |=> score_q[a] == '0);
   end

   always_comb begin
      int best;
      best = 0;
      for (int a = 1; a < NA; a++)
         if (score_q[a] > score_q[best]) best = a;
      winner = SEL_W'(best);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        active_q <= '0;
      else if (!dyn_mode) active_q <= static_map;
      else if (boundary)  active_q <= winner;
   end

   assign active = dyn_mode ? active_q : static_map;

   assert_active_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dyn_mode && !boundary) |=> $stable(active_q));
   assert_active_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      active < NA_V);
endmodule

// File: rtl/outport_predictor.sv
module outport_predictor
   import op_pred_pkg::*;
#(
   parameter int IN_PORT    = 2,
   parameter int FREQ_W     = 4,
   parameter int HIT_W      = 8,
   parameter int INTERVAL_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  chan_idle,
   input  logic                  head_valid,
   input  logic [4:0]            head_port,
   input  logic                  dyn_mode,
   input  logic [1:0]            static_sel,
   input  logic [INTERVAL_W-1:0] interval,
   output logic [4:0]            pred_port,
   output logic                  pred_valid,
   output logic                  hit_valid,
   output logic                  hit
);
   localparam logic [NPORTS-1:0] STRAIGHT = straight_of(IN_PORT);

   if (IN_PORT < 0 || IN_PORT >= NPORTS) begin : g_bad_port
      $error("outport_predictor: IN_PORT out of range");
   end

   logic [NPORTS-1:0] pred_alg [NALG];
   logic [NALG-1:0]   alg_hit;
   logic [ALG_W-1:0]  active;

   assign pred_alg[0] = STRAIGHT;

   op_last_pred #(.NP(NPORTS), .RESET_PORT(STRAIGHT)) last_i (
      .clk(clk), .rst_n(rst_n), .upd(head_valid), .port(head_port), .pred(pred_alg[1]));

   op_freq_pred #(.NP(NPORTS), .CNT_W(FREQ_W)) freq_i (
      .clk(clk), .rst_n(rst_n), .upd(head_valid), .port(head_port), .pred(pred_alg[2]));

   for (genvar a = 0; a < NALG; a++) begin : g_cmp
      assign alg_hit[a] = (pred_alg[a] == head_port);
   end

   op_scoreboard #(.NA(NALG), .SEL_W(ALG_W), .HIT_W(HIT_W), .INTERVAL_W(INTERVAL_W)) sb_i (
      .clk(clk), .rst_n(rst_n), .dyn_mode(dyn_mode), .interval(interval),
      .static_sel(static_sel), .upd(head_valid), .alg_hit(alg_hit), .active(active));

   assign pred_port  = pred_alg[active];
   assign pred_valid = chan_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_valid <= 1'b0;
         hit       <= 1'b0;
      end else begin
         hit_valid <= head_valid;
         hit       <= head_valid && (head_port == pred_port);
      end
   end

   assert_hit_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid |-> $past(head_valid));
   assert_pred_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pred_port) == 1);
   assert_head_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      head_valid |-> $countones(head_port) == 1);
endmodule

// File: tb/outport_predictor_tb_top.sv
module outport_predictor_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [4:0] P_L = 5'b00001, P_XP = 5'b00010, P_XM = 5'b00100,
                          P_YP = 5'b01000, P_YM = 5'b10000;

   logic clk = 0, rst_n = 0, chan_idle = 0, head_valid = 0, dyn_mode = 0;
   logic [4:0] head_port = '0;
   logic [1:0] static_sel = '0;
   logic [15:0] interval = 16'd10000;
   logic [4:0] pred_port;
   logic pred_valid, hit_valid, hit;

   int checks = 0, errors = 0;
   int m_cnt [5];
   logic [4:0] m_last;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   outport_predictor dut_i (
      .clk(clk), .rst_n(rst_n), .chan_idle(chan_idle), .head_valid(head_valid),
      .head_port(head_port), .dyn_mode(dyn_mode), .static_sel(static_sel),
      .interval(interval), .pred_port(pred_port), .pred_valid(pred_valid),
      .hit_valid(hit_valid), .hit(hit));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [4:0] m_freq();
      int best = 0;
      for (int i = 1; i < 5; i++) if (m_cnt[i] > m_cnt[best]) best = i;
      return 5'(1 << best);
   endfunction

   function automatic logic [4:0] m_pred();
      case (static_sel)
         2'd1:    return m_last;
         2'd2:    return m_freq();
         default: return P_XP;
      endcase
   endfunction

   function automatic void m_update(input logic [4:0] p);
      int idx = 0;
      for (int i = 0; i < 5; i++) if (p[i]) idx = i;
      m_last = p;
      if (m_cnt[idx] == 14) begin
         for (int i = 0; i < 5; i++) m_cnt[i] = m_cnt[i] / 2;
         m_cnt[idx] = 7;
      end else m_cnt[idx]++;
   endfunction

   // Called at a negedge; presents one head flit for one cycle.
   task automatic send_head(input logic [4:0] p, input bit check_pred, input string req);
      logic [4:0] exp;
      exp = m_pred();
      if (check_pred) chk(pred_port == exp, req, pred_port, exp);
      head_valid = 1; head_port = p;
      @(negedge clk);
      head_valid = 0; head_port = '0;
      chk(hit_valid == 1'b1, "R9", hit_valid, 1);
      if (check_pred) chk(hit == (p == exp), "R9", hit, (p == exp));
      m_update(p);
   endtask

   task automatic t_reset();
      for (int i = 0; i < 5; i++) m_cnt[i] = 0;
      m_last = P_XP;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(pred_valid == 0, "R1", pred_valid, 0);
      chk(hit_valid == 0, "R9", hit_valid, 0);
      chk(pred_port == P_XP, "R2", pred_port, P_XP);
      static_sel = 2'd2; #1;
      chk(pred_port == P_L, "R4", pred_port, P_L);
      static_sel = 2'd1; #1;
      chk(pred_port == P_XP, "R3", pred_port, P_XP);
      static_sel = 2'd0;
      @(negedge clk);
      chk(hit_valid == 0, "R9", hit_valid, 0);
   endtask

   task automatic t_straight();
      static_sel = 2'd0; chan_idle = 1; #1;
      chk(pred_valid == 1, "R1", pred_valid, 1);
      send_head(P_XP, 1, "R2");
      send_head(P_YP, 1, "R2");
      chan_idle = 0; #1;
      chk(pred_valid == 0, "R1", pred_valid, 0);
      chk(pred_port == P_XP, "R1", pred_port, P_XP);
      chan_idle = 1;
   endtask

   task automatic t_last();
      static_sel = 2'd1; #1;
      chk(pred_port == P_YP, "R3", pred_port, P_YP);
      send_head(P_YM, 1, "R3");
      chk(pred_port == P_YM, "R3", pred_port, P_YM);
   endtask

   task automatic t_freq();
      static_sel = 2'd2; #1;
      chk(pred_port == P_XP, "R4", pred_port, P_XP);
      for (int k = 0; k < 14; k++) send_head(P_YM, 1, "R4");
      for (int k = 0; k < 7; k++) send_head(P_XP, 1, "R5");
      // After halving: X+ 7, Y- 7, tie to lower index.
      chk(pred_port == P_XP, "R5", pred_port, P_XP);
   endtask

   task automatic t_static_code3();
      static_sel = 2'd3; #1;
      chk(pred_port == P_XP, "R6", pred_port, P_XP);
      static_sel = 2'd1; #1;
      chk(pred_port == P_XP, "R6", pred_port, P_XP);
      static_sel = 2'd2;
   endtask

   task automatic t_dynamic();
      interval = 16'd20; dyn_mode = 1;
      // Posedge k after this point ends interval when k = 20, 40.
      for (int k = 0; k < 4; k++) send_head(P_YP, 0, "R7");
      repeat (26) @(negedge clk);
      chk(pred_port == P_YP, "R7", pred_port, P_YP);
      repeat (15) @(negedge clk);
      chk(pred_port == P_XP, "R8", pred_port, P_XP);
      dyn_mode = 0; static_sel = 2'd1; #1;
      chk(pred_port == P_YP, "R6", pred_port, P_YP);
   endtask

   initial begin
      t_reset();
      t_straight();
      t_last();
      t_freq();
      t_static_code3();
      t_dynamic();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule